// File: doc/BRIEF.md
# Self-Supply and Overload Fault Sequencer

This block governs the power-up and fault behaviour of an offline flyback controller that runs from its own high-voltage startup source. It reads four supply-voltage comparator flags, already synchronised: the supply has reached the upper level (12 V), has dropped under the turn-on level (10 V), has dropped under the undervoltage level (9.8 V), or has dropped under the restart level (5.3 V). It also reads an overload flag derived from the feedback pin and a latched over-voltage flag. From these it drives the high-voltage current-source enable, a gate-pulse permit for the cycle controller, a one-cycle soft-start restart strobe and a standby indication. It also produces an 8-bit peak-current clamp code that ramps up after each restart.

The sequencer is a four-state machine with the states `ST_STARTUP`, `ST_DRAIN`, `ST_RECHARGE` and `ST_LATCHOFF`. `ST_STARTUP` charges the supply capacitor with pulses held off. `ST_DRAIN` lets the capacitor discharge while the converter switches and the overload flag is watched. `ST_RECHARGE` turns the source back on while switching continues. `ST_LATCHOFF` shuts everything down until the capacitor has bled to the restart level.

The transitions are as follows:
- **T_POWERED** (`ST_STARTUP` to `ST_DRAIN`, upper level reached) fires the soft-start strobe.
- **T_REFILL** (`ST_DRAIN` to `ST_RECHARGE`) is taken at the turn-on level when neither the overload flag nor the over-voltage flag is set.
- **T_TRIP** (`ST_DRAIN` to `ST_LATCHOFF`) is taken at the turn-on level when either flag is set.
- **T_FULL** (`ST_RECHARGE` to `ST_DRAIN`) is taken at the upper level.
- **T_RESTART** (`ST_LATCHOFF` to `ST_STARTUP`) is taken at the restart level.

The overload delay is therefore the time the capacitor takes to fall from 12 V to 10 V, with no counter involved.

Top module: `supply_seq`

## Requirements
- R1: After reset, and in `ST_STARTUP`, `hv_src_en`=1 and `pulse_ok`=0. Both stay so until `vcc_ge_hi` is seen at a clock edge.
- R2: On the edge where `vcc_ge_hi` is seen in `ST_STARTUP`, `ss_restart` is 1 for that one cycle only. After the edge, `hv_src_en`=0 and `pulse_ok`=1.
- R3: While pulsing, the source turns on at the first edge that sees `vcc_lt_on` with no fault pending. It turns off at the first edge that then sees `vcc_ge_hi`. `pulse_ok` stays 1 throughout.
- R4: `pulse_ok` is 0 in the same cycle that `vcc_lt_uvlo` is 1, in any state.
- R5: If `overload` is 1 at the edge that sees `vcc_lt_on` in `ST_DRAIN`, the block enters latchoff. There `standby`=1, `hv_src_en`=0 and `pulse_ok`=0. This holds, whatever the flags do, until an edge sees `vcc_lt_rst`.
- R6: `overload` has no effect unless it is present at that 10 V edge. An overload that clears before then leads to `ST_RECHARGE` with `standby`=0.
- R7: The edge that sees `vcc_lt_rst` in latchoff returns to `ST_STARTUP`: source on, no pulses. Pulses resume, and a new soft-start strobe fires, at the next `vcc_ge_hi`.
- R8: `ss_clamp` is 0 from reset until the first strobe. The strobe edge loads 0, and the code then rises by one every RAMP_CYCLES/256 cycles, holding at 255.
- R9: While `ovp_lock`=1, `pulse_ok` is 0. The turn-on crossing then leads to latchoff rather than recharge, so the supply keeps cycling between the restart and upper levels.
- R10: `hv_src_en` and `standby` are never 1 together, and `standby`=1 never coincides with `pulse_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_ge_hi | input | 1 | Supply at or above 12 V |
| vcc_lt_on | input | 1 | Supply below 10 V |
| vcc_lt_uvlo | input | 1 | Supply below 9.8 V |
| vcc_lt_rst | input | 1 | Supply below 5.3 V |
| overload | input | 1 | Feedback pin indicates overload |
| ovp_lock | input | 1 | Over-voltage latched |
| hv_src_en | output | 1 | High-voltage startup source enable |
| pulse_ok | output | 1 | Gate pulses permitted |
| ss_restart | output | 1 | One-cycle soft-start restart strobe |
| standby | output | 1 | Latchoff / low-power standby |
| ss_clamp | output | 8 | Soft-start peak-current clamp code |

## Verification
The assertions assume the comparator flags describe a single physical supply voltage. Under that assumption the upper-level flag is never set together with any of the falling flags, and each lower flag implies the ones above it (restart implies undervoltage, which implies turn-on). The bench keeps to this by driving a supply voltage in millivolts and deriving all four flags from it, never setting them independently. The overload and over-voltage flags are toggled freely, including in the cycles around the turn-on crossing, where they decide between recharge and latchoff.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

    typedef enum logic [1:0] {
        ST_STARTUP  = 2'd0,
        ST_DRAIN    = 2'd1,
        ST_RECHARGE = 2'd2,
        ST_LATCHOFF = 2'd3
    } seq_state_t;

    localparam int CLAMP_W = 8;

endpackage

// File: rtl/supply_fsm.sv
module supply_fsm
    import supply_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       above_hi,
    input  logic       below_on,
    input  logic       below_uvlo,
    input  logic       below_restart,
    input  logic       overload,
    input  logic       ovp_lock,
    output logic       src_en,
    output logic       pulse_en,
    output logic       ss_kick,
    output logic       standby,
    output seq_state_t state_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STARTUP;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STARTUP:  if (above_hi)      state_d = ST_DRAIN;                       // T_POWERED
            ST_DRAIN:    if (below_on)      state_d = (overload || ovp_lock) ?
                                                      ST_LATCHOFF : ST_RECHARGE;     // T_TRIP / T_REFILL
            ST_RECHARGE: if (above_hi)      state_d = ST_DRAIN;                       // T_FULL
            ST_LATCHOFF: if (below_restart) state_d = ST_STARTUP;                     // T_RESTART
            default:                        state_d = ST_STARTUP;
        endcase
    end

    // outputs
    always_comb begin
        src_en   = 1'b0;
        pulse_en = 1'b0;
        ss_kick  = 1'b0;
        standby  = 1'b0;
        unique case (state_q)
            ST_STARTUP: begin
                src_en  = 1'b1;
                ss_kick = above_hi;
            end
            ST_DRAIN: begin
                pulse_en = !below_uvlo && !ovp_lock;
            end
            ST_RECHARGE: begin
                src_en   = 1'b1;
                pulse_en = !below_uvlo && !ovp_lock;
            end
            ST_LATCHOFF: begin
                standby = 1'b1;
            end
            default: begin
                src_en = 1'b1;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
    parameter int RAMP_CYCLES = 1024,
    parameter int CODE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    output logic [CODE_W-1:0] code
);

    localparam int LEVELS = 1 << CODE_W;
    localparam int STEP   = (RAMP_CYCLES >= LEVELS) ? (RAMP_CYCLES / LEVELS) : 1;
    localparam int CNT_W  = (STEP > 1) ? $clog2(STEP) : 1;
    localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

    logic              running;
    logic              step_hit;
    logic [CODE_W-1:0] code_q;

    generate
        if (STEP > 1) begin : g_div
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                    cnt_q <= '0;
                else if (kick)                 cnt_q <= '0;
                else if (running && step_hit)  cnt_q <= '0;
                else if (running)              cnt_q <= cnt_q + 1'b1;
            end
            assign step_hit = (cnt_q == CNT_W'(STEP - 1));
        end else begin : g_nodiv
            assign step_hit = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            running <= 1'b0;
        end else if (kick) begin
            code_q  <= '0;
            running <= 1'b1;
        end else if (running && step_hit) begin
            code_q <= code_q + 1'b1;
            if (code_q == CODE_TOP - 1'b1) running <= 1'b0;
        end
    end

    assign code = code_q;

endmodule

// File: rtl/supply_seq.sv
module supply_seq
    import supply_seq_pkg::*;
#(
    parameter int RAMP_CYCLES = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vcc_ge_hi,
    input  logic               vcc_lt_on,
    input  logic               vcc_lt_uvlo,
    input  logic               vcc_lt_rst,
    input  logic               overload,
    input  logic               ovp_lock,
    output logic               hv_src_en,
    output logic               pulse_ok,
    output logic               ss_restart,
    output logic               standby,
    output logic [CLAMP_W-1:0] ss_clamp
);

    seq_state_t cur_state;

    supply_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .above_hi      (vcc_ge_hi),
        .below_on      (vcc_lt_on),
        .below_uvlo    (vcc_lt_uvlo),
        .below_restart (vcc_lt_rst),
        .overload      (overload),
        .ovp_lock      (ovp_lock),
        .src_en        (hv_src_en),
        .pulse_en      (pulse_ok),
        .ss_kick       (ss_restart),
        .standby       (standby),
        .state_o       (cur_state)
    );

    ss_ramp #(
        .RAMP_CYCLES (RAMP_CYCLES),
        .CODE_W      (CLAMP_W)
    ) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (ss_restart),
        .code  (ss_clamp)
    );

endmodule

// File: rtl/supply_seq_chk.sv
module supply_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_ge_hi,
    input logic       vcc_lt_on,
    input logic       vcc_lt_uvlo,
    input logic       vcc_lt_rst,
    input logic       overload,
    input logic       ovp_lock,
    input logic       hv_src_en,
    input logic       pulse_ok,
    input logic       ss_restart,
    input logic       standby,
    input logic [7:0] ss_clamp
);

    a_r2_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart |=> !ss_restart && pulse_ok == !(vcc_lt_uvlo || ovp_lock));

    a_r2_src_drops_at_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_src_en && vcc_ge_hi) |=> !hv_src_en);

    a_r4_uvlo_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_lt_uvlo |-> !pulse_ok);

    a_r5_trip_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> $past(vcc_lt_on) && ($past(overload) || $past(ovp_lock)));

    a_r5_hold_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !vcc_lt_rst) |=> standby);

    a_r7_restart_src: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && vcc_lt_rst) |=> hv_src_en && !pulse_ok && !standby);

    a_r8_clamp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart |=> ss_clamp == 8'd0);

    a_r8_clamp_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_restart |=> ss_clamp >= $past(ss_clamp));

    a_r9_ovp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_lock |-> !pulse_ok);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !hv_src_en && !pulse_ok);

endmodule

bind supply_seq supply_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vcc_ge_hi   (vcc_ge_hi),
    .vcc_lt_on   (vcc_lt_on),
    .vcc_lt_uvlo (vcc_lt_uvlo),
    .vcc_lt_rst  (vcc_lt_rst),
    .overload    (overload),
    .ovp_lock    (ovp_lock),
    .hv_src_en   (hv_src_en),
    .pulse_ok    (pulse_ok),
    .ss_restart  (ss_restart),
    .standby     (standby),
    .ss_clamp    (ss_clamp)
);

// File: tb/supply_seq_tb.sv
`timescale 1ns/1ps
module supply_seq_tb;

    localparam int RAMP = 1024;
    localparam int STEP = RAMP / 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   vcc_mv = 0;
    logic overload = 1'b0;
    logic ovp_lock = 1'b0;
    logic hv_src_en, pulse_ok, ss_restart, standby;
    logic [7:0] ss_clamp;

    wire vcc_ge_hi   = (vcc_mv >= 12000);
    wire vcc_lt_on   = (vcc_mv < 10000);
    wire vcc_lt_uvlo = (vcc_mv < 9800);
    wire vcc_lt_rst  = (vcc_mv < 5300);

    always #2.5 clk = ~clk;

    supply_seq #(.RAMP_CYCLES(RAMP)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .vcc_ge_hi (vcc_ge_hi), .vcc_lt_on (vcc_lt_on),
        .vcc_lt_uvlo (vcc_lt_uvlo), .vcc_lt_rst (vcc_lt_rst),
        .overload (overload), .ovp_lock (ovp_lock),
        .hv_src_en (hv_src_en), .pulse_ok (pulse_ok),
        .ss_restart (ss_restart), .standby (standby), .ss_clamp (ss_clamp)
    );

    // behavioural reference: phase 0 charging from cold, 1 switching on capacitor,
    // 2 switching with source on, 3 shut down waiting for the restart level
    int    phase = 0;
    int    age   = -1;
    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R10";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= 0;
            age   <= -1;
        end else begin
            if (phase == 0 && vcc_ge_hi) age <= 0;
            else if (age >= 0 && age < 100000) age <= age + 1;
            case (phase)
                0: if (vcc_ge_hi) phase <= 1;
                1: if (vcc_lt_on) phase <= (overload || ovp_lock) ? 3 : 2;
                2: if (vcc_ge_hi) phase <= 1;
                default: if (vcc_lt_rst) phase <= 0;
            endcase
        end
    end

    function automatic int exp_code();
        if (age < 0) return 0;
        return (age / STEP > 255) ? 255 : age / STEP;
    endfunction

    task automatic compare();
        logic e_src, e_pulse, e_kick, e_stby;
        int   e_code;
        e_src   = (phase == 0 || phase == 2);
        e_pulse = (phase == 1 || phase == 2) && !vcc_lt_uvlo && !ovp_lock;
        e_kick  = (phase == 0) && vcc_ge_hi;
        e_stby  = (phase == 3);
        e_code  = exp_code();
        checks++;
        if (hv_src_en !== e_src || pulse_ok !== e_pulse || ss_restart !== e_kick ||
            standby !== e_stby || int'(ss_clamp) != e_code) begin
            errors++;
            $display("FAIL %s t=%0t actual src=%b pulse=%b kick=%b stby=%b clamp=%0d expected src=%b pulse=%b kick=%b stby=%b clamp=%0d",
                     cur_req, $time, hv_src_en, pulse_ok, ss_restart, standby, ss_clamp,
                     e_src, e_pulse, e_kick, e_stby, e_code);
        end
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(posedge clk);
            #1 compare();
            #1;
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        vcc_mv = 0;
        #12 compare();                 // R10 reset values
        rst_n = 1'b1;
        cur_req = "R1";   vcc_mv = 3000; run(3);
        vcc_mv = 8000;                 run(3);
        vcc_mv = 11500;                run(3);
        cur_req = "R2";   vcc_mv = 12000; run(3);
        cur_req = "R8";   vcc_mv = 11000; run(300);
        cur_req = "R3";   vcc_mv = 9900;  run(4);
        vcc_mv = 11000;                run(4);
        vcc_mv = 12000;                run(2);
        vcc_mv = 11000;                run(4);
        cur_req = "R4";   vcc_mv = 9700;  run(4);
        vcc_mv = 9900;                 run(2);
        vcc_mv = 12000;                run(2);
        cur_req = "R6";   vcc_mv = 11000; overload = 1'b1; run(5);
        overload = 1'b0;               run(2);
        vcc_mv = 9900;                 run(4);
        vcc_mv = 12000;                run(2);
        cur_req = "R5";   vcc_mv = 10500; overload = 1'b1; run(3);
        vcc_mv = 9900;                 run(3);
        overload = 1'b0;  vcc_mv = 12000; run(3);
        vcc_mv = 7000;                 run(3);
        cur_req = "R7";   vcc_mv = 5000;  run(3);
        vcc_mv = 9000;                 run(3);
        vcc_mv = 12000;                run(2);
        cur_req = "R8";   vcc_mv = 11000; run(1100);
        cur_req = "R9";   ovp_lock = 1'b1; run(3);
        vcc_mv = 9900;                 run(3);
        vcc_mv = 5000;                 run(3);
        vcc_mv = 12000;                run(3);
        vcc_mv = 11000;                run(3);
        vcc_mv = 9900;                 run(3);
        cur_req = "R10";  ovp_lock = 1'b0; vcc_mv = 5000; run(3);
        vcc_mv = 12000;                run(3);
        finish_up();
    end

endmodule